// File: doc/BRIEF.md
# Operand Bypass Select and Load-Use Interlock

This block decides, every cycle, where each of the two ALU operands of the instruction in the execute stage of a five-stage pipeline comes from. The options are the value read from the register file, the result still held in the memory stage, or the result about to be written back. When both later stages hold a definition of the same register, the memory stage wins, because it carries the younger definition. Register zero is never bypassed. The register file is assumed to return a value written in the same cycle, so dependences three or more instructions apart need no bypass.

The block also finds the one hazard that bypassing cannot hide. If the instruction in execute is a load, and the instruction in decode reads the register that load writes, the loaded data does not exist yet. The block then raises a stall for one cycle. The surrounding pipeline uses it to hold the program counter and the fetch/decode register, and to put a bubble into the decode/execute register. The selects and the stall are purely combinational from the stage fields. The operand muxes belong to the datapath outside this block.

Top module: `fwd_unit`

## Requirements
- R1: `fwdSelA` is `2'b10` (memory-stage result) when `exRs` is nonzero, equals `memDest`, and `memRegWr` is high.
- R2: When R1 does not apply, `fwdSelA` is `2'b01` (write-back result) when `exRs` is nonzero, equals `wbDest`, and `wbRegWr` is high.
- R3: When neither R1 nor R2 applies, `fwdSelA` is `2'b00` (register-file value). The value `2'b11` is never produced.
- R4: When both the memory and write-back stages write the register named by an execute source, the select is `2'b10`.
- R5: A source field of zero always gives select `2'b00`, even if a later stage writes register zero.
- R6: `fwdSelB` follows R1 to R5 using `exRt` in place of `exRs`. The two selects are independent of each other.
- R7: `loadUseStall` is high when `exMemRd` and `exRegWr` are high, `exDest` is nonzero, and either `idRs` equals `exDest` with `idUseRs` high, or `idRt` equals `exDest` with `idUseRt` high.
- R8: `loadUseStall` is low when the execute instruction is not a load, when it does not write a register, when its destination is zero, or when the matching decode source is not used.
- R9: The load and decode inputs have no effect on `fwdSelA` or `fwdSelB`, and the memory and write-back stage inputs have no effect on `loadUseStall`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the bound property checker |
| rst_n | input | 1 | Active-low reset that disables the checker |
| exRs | input | REG_AW | First source register of the execute-stage instruction |
| exRt | input | REG_AW | Second source register of the execute-stage instruction |
| idRs | input | REG_AW | First source register of the decode-stage instruction |
| idRt | input | REG_AW | Second source register of the decode-stage instruction |
| idUseRs | input | 1 | Decode-stage instruction reads its first source |
| idUseRt | input | 1 | Decode-stage instruction reads its second source |
| exDest | input | REG_AW | Destination register of the execute-stage instruction |
| exRegWr | input | 1 | Execute-stage instruction writes the register file |
| exMemRd | input | 1 | Execute-stage instruction is a load |
| memDest | input | REG_AW | Destination register of the memory-stage instruction |
| memRegWr | input | 1 | Memory-stage instruction writes the register file |
| wbDest | input | REG_AW | Destination register of the write-back-stage instruction |
| wbRegWr | input | 1 | Write-back-stage instruction writes the register file |
| fwdSelA | output | 2 | Operand A source: 00 register file, 10 memory stage, 01 write-back |
| fwdSelB | output | 2 | Operand B source, same encoding |
| loadUseStall | output | 1 | Hold PC and fetch/decode register, bubble decode/execute |

## Verification
The hardest case to reach is a register that has definitions in both the memory and write-back stages while a load in execute targets the same register that the decode instruction reads. Under uniform random fields over 32 registers, this coincidence almost never happens. The stimulus therefore draws most register numbers from a tiny pool that includes zero, so that double matches, zero-register writes and load-use overlaps occur on many cycles. Directed vectors then pin down each priority and exclusion case.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // number of execute-stage source operands handled
  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwdSel_e;

  // strobes from the compare datapath to the select control
  typedef struct packed {
    logic [NUM_SRC-1:0] memHit;
    logic [NUM_SRC-1:0] wbHit;
    logic [NUM_SRC-1:0] loadHit;
  } hazStrobes_t;

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] srcReg,
  input  logic [REG_AW-1:0] dstReg,
  input  logic              dstValid,
  output logic              hit
);
  logic srcNonZero;
  logic sameReg;

  always_comb begin
    srcNonZero = |srcReg;
    sameReg    = (srcReg == dstReg);
    hit        = dstValid & srcNonZero & sameReg;
  end
endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [NUM_SRC-1:0][REG_AW-1:0] exSrc,
  input  logic [NUM_SRC-1:0][REG_AW-1:0] idSrc,
  input  logic [NUM_SRC-1:0]             idUse,
  input  logic [REG_AW-1:0]              exDest,
  input  logic                           exRegWr,
  input  logic                           exMemRd,
  input  logic [REG_AW-1:0]              memDest,
  input  logic                           memRegWr,
  input  logic [REG_AW-1:0]              wbDest,
  input  logic                           wbRegWr,
  output hazStrobes_t                    strobes
);
  logic                 exIsLoad;
  logic [NUM_SRC-1:0]   memHitVec;
  logic [NUM_SRC-1:0]   wbHitVec;
  logic [NUM_SRC-1:0]   loadHitVec;

  assign exIsLoad = exRegWr & exMemRd;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    // execute source against memory-stage producer
    fwd_match #(.REG_AW(REG_AW)) u_memMatch (
      .srcReg  (exSrc[g]),
      .dstReg  (memDest),
      .dstValid(memRegWr),
      .hit     (memHitVec[g])
    );
    // execute source against write-back producer
    fwd_match #(.REG_AW(REG_AW)) u_wbMatch (
      .srcReg  (exSrc[g]),
      .dstReg  (wbDest),
      .dstValid(wbRegWr),
      .hit     (wbHitVec[g])
    );
    // decode source against a load sitting in execute
    fwd_match #(.REG_AW(REG_AW)) u_loadMatch (
      .srcReg  (idSrc[g]),
      .dstReg  (exDest),
      .dstValid(exIsLoad & idUse[g]),
      .hit     (loadHitVec[g])
    );
  end

  always_comb begin
    strobes         = '0;
    strobes.memHit  = memHitVec;
    strobes.wbHit   = wbHitVec;
    strobes.loadHit = loadHitVec;
  end
endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
(
  input  hazStrobes_t              strobes,
  output logic [NUM_SRC-1:0][1:0]  selVec,
  output logic                     stall
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sel
    fwdSel_e pick;
    always_comb begin
      // youngest producer is checked first
      if (strobes.memHit[g])     pick = SEL_MEM;
      else if (strobes.wbHit[g]) pick = SEL_WB;
      else                       pick = SEL_RF;
      selVec[g] = pick;
    end
  end

  assign stall = |strobes.loadHit;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] exRs,
  input  logic [REG_AW-1:0] exRt,
  input  logic [REG_AW-1:0] idRs,
  input  logic [REG_AW-1:0] idRt,
  input  logic              idUseRs,
  input  logic              idUseRt,
  input  logic [REG_AW-1:0] exDest,
  input  logic              exRegWr,
  input  logic              exMemRd,
  input  logic [REG_AW-1:0] memDest,
  input  logic              memRegWr,
  input  logic [REG_AW-1:0] wbDest,
  input  logic              wbRegWr,
  output logic [1:0]        fwdSelA,
  output logic [1:0]        fwdSelB,
  output logic              loadUseStall
);
  localparam int OP_A = 0;
  localparam int OP_B = 1;

  logic [NUM_SRC-1:0][REG_AW-1:0] exSrc;
  logic [NUM_SRC-1:0][REG_AW-1:0] idSrc;
  logic [NUM_SRC-1:0]             idUse;
  logic [NUM_SRC-1:0][1:0]        selVec;
  hazStrobes_t                    strobes;

  assign exSrc[OP_A] = exRs;
  assign exSrc[OP_B] = exRt;
  assign idSrc[OP_A] = idRs;
  assign idSrc[OP_B] = idRt;
  assign idUse[OP_A] = idUseRs;
  assign idUse[OP_B] = idUseRt;

  fwd_datapath #(.REG_AW(REG_AW)) u_dp (
    .exSrc   (exSrc),
    .idSrc   (idSrc),
    .idUse   (idUse),
    .exDest  (exDest),
    .exRegWr (exRegWr),
    .exMemRd (exMemRd),
    .memDest (memDest),
    .memRegWr(memRegWr),
    .wbDest  (wbDest),
    .wbRegWr (wbRegWr),
    .strobes (strobes)
  );

  fwd_ctrl u_ctrl (
    .strobes(strobes),
    .selVec (selVec),
    .stall  (loadUseStall)
  );

  assign fwdSelA = selVec[OP_A];
  assign fwdSelB = selVec[OP_B];
endmodule

// File: rtl/fwd_unit_checker.sv
module fwd_unit_checker #(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] exRs,
  input logic [REG_AW-1:0] exRt,
  input logic [REG_AW-1:0] idRs,
  input logic [REG_AW-1:0] idRt,
  input logic              idUseRs,
  input logic              idUseRt,
  input logic [REG_AW-1:0] exDest,
  input logic              exRegWr,
  input logic              exMemRd,
  input logic [REG_AW-1:0] memDest,
  input logic              memRegWr,
  input logic [REG_AW-1:0] wbDest,
  input logic              wbRegWr,
  input logic [1:0]        fwdSelA,
  input logic [1:0]        fwdSelB,
  input logic              loadUseStall
);
  AST_A_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (exRs != '0 && exRs == memDest && memRegWr) |-> fwdSelA == 2'b10); // R1

  AST_A_FROM_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (exRs != '0 && exRs == wbDest && wbRegWr && !(exRs == memDest && memRegWr))
      |-> fwdSelA == 2'b01); // R2

  AST_A_FROM_RF: assert property (@(posedge clk) disable iff (!rst_n)
    (!(exRs == memDest && memRegWr) && !(exRs == wbDest && wbRegWr))
      |-> fwdSelA == 2'b00); // R3

  AST_NEVER_ELEVEN: assert property (@(posedge clk) disable iff (!rst_n)
    fwdSelA != 2'b11 && fwdSelB != 2'b11); // R3

  AST_MEM_BEATS_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (exRt != '0 && exRt == memDest && exRt == wbDest && memRegWr && wbRegWr)
      |-> fwdSelB == 2'b10); // R4

  AST_ZERO_NOT_BYPASSED: assert property (@(posedge clk) disable iff (!rst_n)
    (exRs == '0 |-> fwdSelA == 2'b00) and (exRt == '0 |-> fwdSelB == 2'b00)); // R5

  AST_B_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (exRt != '0 && exRt == memDest && memRegWr) |-> fwdSelB == 2'b10); // R6

  AST_LOAD_USE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (exMemRd && exRegWr && exDest != '0 &&
     ((idUseRs && idRs == exDest) || (idUseRt && idRt == exDest)))
      |-> loadUseStall); // R7

  AST_NO_STALL_NONLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!exMemRd || !exRegWr || exDest == '0) |-> !loadUseStall); // R8

  AST_STALL_NEEDS_USE: assert property (@(posedge clk) disable iff (!rst_n)
    (!idUseRs && !idUseRt) |-> !loadUseStall); // R8

  AST_SEL_IGNORES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!memRegWr && !wbRegWr) |-> (fwdSelA == 2'b00 && fwdSelB == 2'b00)); // R9
endmodule

bind fwd_unit fwd_unit_checker #(.REG_AW(REG_AW)) u_fwdChk (
  .clk         (clk),
  .rst_n       (rst_n),
  .exRs        (exRs),
  .exRt        (exRt),
  .idRs        (idRs),
  .idRt        (idRt),
  .idUseRs     (idUseRs),
  .idUseRt     (idUseRt),
  .exDest      (exDest),
  .exRegWr     (exRegWr),
  .exMemRd     (exMemRd),
  .memDest     (memDest),
  .memRegWr    (memRegWr),
  .wbDest      (wbDest),
  .wbRegWr     (wbRegWr),
  .fwdSelA     (fwdSelA),
  .fwdSelB     (fwdSelB),
  .loadUseStall(loadUseStall)
);

// File: tb/tb_fwd_unit.sv
`timescale 1ns/1ps
module tb_fwd_unit;
  localparam int AW = 5;
  localparam int RANDOM_CYCLES = 4000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] exRs = '0, exRt = '0, idRs = '0, idRt = '0;
  logic          idUseRs = 1'b0, idUseRt = 1'b0;
  logic [AW-1:0] exDest = '0, memDest = '0, wbDest = '0;
  logic          exRegWr = 1'b0, exMemRd = 1'b0, memRegWr = 1'b0, wbRegWr = 1'b0;
  logic [1:0]    fwdSelA, fwdSelB;
  logic          loadUseStall;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fwd_unit #(.REG_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .exRs(exRs), .exRt(exRt), .idRs(idRs), .idRt(idRt),
    .idUseRs(idUseRs), .idUseRt(idUseRt),
    .exDest(exDest), .exRegWr(exRegWr), .exMemRd(exMemRd),
    .memDest(memDest), .memRegWr(memRegWr),
    .wbDest(wbDest), .wbRegWr(wbRegWr),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB), .loadUseStall(loadUseStall)
  );

  typedef struct { int dest; bit wr; logic [1:0] code; } producer_t;

  // reference: walk outstanding producers from youngest to oldest
  function automatic logic [1:0] refSel(int src);
    producer_t inflight[$];
    inflight.push_back('{int'(memDest), memRegWr, 2'b10});
    inflight.push_back('{int'(wbDest),  wbRegWr,  2'b01});
    if (src == 0) return 2'b00;
    foreach (inflight[i])
      if (inflight[i].wr && inflight[i].dest == src) return inflight[i].code;
    return 2'b00;
  endfunction

  function automatic bit refStall();
    int readers[$];
    if (!(exMemRd && exRegWr) || exDest == 0) return 1'b0;
    if (idUseRs) readers.push_back(int'(idRs));
    if (idUseRt) readers.push_back(int'(idRt));
    foreach (readers[i]) if (readers[i] == int'(exDest)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string selTag(int src, bit isB);
    bit m = memRegWr && int'(memDest) == src;
    bit w = wbRegWr && int'(wbDest) == src;
    string t;
    if (src == 0) t = "R5";
    else if (m && w) t = "R4";
    else if (m) t = "R1";
    else if (w) t = "R2";
    else t = "R3";
    return isB ? {"R6/", t} : t;
  endfunction

  task automatic checkAll(string ctx);
    logic [1:0] eA, eB;
    bit eS;
    eA = refSel(int'(exRs));
    eB = refSel(int'(exRt));
    eS = refStall();
    checks += 3;
    if (fwdSelA !== eA) begin
      fails++;
      $display("FAIL %s %s fwdSelA actual=%b expected=%b", selTag(int'(exRs), 1'b0), ctx, fwdSelA, eA);
    end
    if (fwdSelB !== eB) begin
      fails++;
      $display("FAIL %s %s fwdSelB actual=%b expected=%b", selTag(int'(exRt), 1'b1), ctx, fwdSelB, eB);
    end
    if (loadUseStall !== eS) begin
      fails++;
      $display("FAIL %s %s loadUseStall actual=%b expected=%b", eS ? "R7" : "R8", ctx, loadUseStall, eS);
    end
  endtask

  task automatic setFields(int ers, int ert, int irs, int irt, bit urs, bit urt,
                           int ed, bit ewr, bit erd, int md, bit mwr, int wd, bit wwr);
    @(negedge clk);
    exRs = AW'(ers); exRt = AW'(ert); idRs = AW'(irs); idRt = AW'(irt);
    idUseRs = urs; idUseRt = urt;
    exDest = AW'(ed); exRegWr = ewr; exMemRd = erd;
    memDest = AW'(md); memRegWr = mwr; wbDest = AW'(wd); wbRegWr = wwr;
    #2;
  endtask

  function automatic int pick();
    return ($urandom_range(0, 9) < 8) ? int'($urandom_range(0, 3)) : int'($urandom_range(0, 31));
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #2 checkAll("reset state R3 R8");
    rst_n = 1'b1;

    setFields(3, 0, 0, 0, 0, 0, 0, 0, 0, 3, 1, 0, 0); checkAll("R1 distance one");
    setFields(3, 0, 0, 0, 0, 0, 0, 0, 0, 5, 1, 3, 1); checkAll("R2 distance two");
    setFields(3, 3, 0, 0, 0, 0, 0, 0, 0, 3, 0, 3, 0); checkAll("R3 writes disabled");
    setFields(7, 7, 0, 0, 0, 0, 0, 0, 0, 7, 1, 7, 1); checkAll("R4 both stages match");
    setFields(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1); checkAll("R5 register zero");
    setFields(2, 9, 0, 0, 0, 0, 0, 0, 0, 9, 1, 2, 1); checkAll("R6 independent operands");
    setFields(1, 1, 4, 0, 1, 0, 4, 1, 1, 0, 0, 0, 0); checkAll("R7 load rs match");
    setFields(1, 1, 0, 4, 0, 1, 4, 1, 1, 0, 0, 0, 0); checkAll("R7 load rt match");
    setFields(1, 1, 4, 4, 0, 0, 4, 1, 1, 0, 0, 0, 0); checkAll("R8 source unused");
    setFields(1, 1, 4, 4, 1, 1, 4, 1, 0, 0, 0, 0, 0); checkAll("R8 not a load");
    setFields(1, 1, 0, 0, 1, 1, 0, 1, 1, 0, 0, 0, 0); checkAll("R8 load to zero");
    setFields(4, 4, 4, 4, 1, 1, 4, 1, 1, 6, 0, 6, 0); checkAll("R9 load leaves selects");
    setFields(6, 6, 6, 6, 1, 1, 2, 1, 1, 6, 1, 6, 1); checkAll("R9 producers leave stall");

    for (int n = 0; n < RANDOM_CYCLES; n++) begin
      setFields(pick(), pick(), pick(), pick(), 1'($urandom), 1'($urandom),
                pick(), 1'($urandom), 1'($urandom), pick(), 1'($urandom),
                pick(), 1'($urandom));
      checkAll("random R1 R2 R3 R4 R5 R6 R7 R8 R9");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule